// File: doc/BRIEF.md
# Memory-to-Stream FIFO Reader

This block is the drain side of a FIFO whose storage is a window of external memory. A local controller keeps a fill level and a read pointer. The fill level counts the words the write side has logged and that this block has not yet handed out. When the level is above a programmable read watermark, a fetch engine issues one read command at the current read address. It then waits for the matching word on the read-data return channel and parks that word in a one-entry holding register. The holding register drives a valid/ready stream source.

When the consumer takes the word, the controller's read strobe fires. That strobe advances the read pointer around the window and lowers the level by one. The write side pulses `wr_log` once for every word it has committed to memory, and the block never looks at that data. A system that wants a start-up cushion sets the watermark above zero. Output then starts only after more than that many words are in the window.

Top module: `mfr_stream_reader`

## Requirements
- R1: The n-th word delivered on the source (counting from 0 after reset) is the data returned for address BASE + (n mod DEPTH), and the read command for it carries exactly that address.
- R2: No read command is issued while the level is less than or equal to RD_THRESH, even if the source has been idle for many cycles.
- R3: `readable` is 1 exactly when `level` is greater than RD_THRESH.
- R4: While `src_valid` is 1 and `src_ready` is 0, the next cycle still has `src_valid` at 1 and the same `src_data`.
- R5: At most one read command is outstanding at any time. `cmd_valid` with its `cmd_addr` stays asserted and unchanged until `cmd_ready`. No command is issued while a word sits in the holding register.
- R6: `level` rises by one on a cycle with `wr_log` and no source handshake. It falls by one on a source handshake without `wr_log`. It is unchanged when both happen in the same cycle.
- R7: `rsp_ready` is 1 only while a read is outstanding and the holding register is empty. A word accepted on the return channel appears with `src_valid` at 1 on the following cycle.
- R8: While `rst` is 1 and on the first cycle after it, `src_valid`, `cmd_valid` and `rsp_ready` are 0, `level` is 0 and `readable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_log | input | 1 | One pulse per word the write side has committed to the window |
| level | output | $clog2(DEPTH+1) | Words logged and not yet consumed |
| readable | output | 1 | Level is above the read watermark |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Read command accepted |
| cmd_addr | output | AW | Read command address |
| rsp_valid | input | 1 | Returned read word valid |
| rsp_ready | output | 1 | Block can accept a returned word |
| rsp_data | input | DW | Returned read word |
| src_valid | output | 1 | Stream word valid |
| src_ready | input | 1 | Consumer takes the stream word |
| src_data | output | DW | Stream word |

## Verification
The write log and the consumer handshake can land on the same clock edge. On that edge the level counter gets an increment and a decrement together. The steady-stream phase raises `wr_log` in the very cycle it raises `src_ready` for every word. Each time it requires the level to come back unchanged and the next fetch to start without a gap in `readable`. A separate drain phase takes handshakes with no write beside them, where each handshake must lower the level by exactly one. That phase ends with the watermark shutting off further commands.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_CMD  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    function automatic int unsigned ptr_width(int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

    function automatic int unsigned level_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/mfr_level_ctrl.sv
module mfr_level_ctrl
    import mfr_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned RD_THRESH = 4,
    parameter int unsigned BASE      = 8,
    parameter int unsigned AW        = 16,
    localparam int unsigned LW       = level_width(DEPTH),
    localparam int unsigned PW       = ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_log,
    input  logic          rd_stb,
    output logic [LW-1:0] level,
    output logic          readable,
    output logic [AW-1:0] rd_addr
);
    localparam logic [LW-1:0] THR  = LW'(RD_THRESH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else if (rd_stb) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            unique case ({wr_log, rd_stb})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign readable = (level > THR);
    assign rd_addr  = AW'(BASE) + AW'(rd_ptr);

endmodule

// File: rtl/mfr_fetch.sv
module mfr_fetch
    import mfr_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          readable,
    input  logic          hold_free,
    input  logic [AW-1:0] rd_addr,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [AW-1:0] cmd_addr,
    input  logic          rsp_valid,
    output logic          rsp_ready,
    output logic          load
);
    fetch_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (readable && hold_free) state_nx = FS_CMD;
            FS_CMD:  if (cmd_ready)             state_nx = FS_WAIT;
            FS_WAIT: if (load)                  state_nx = FS_IDLE;
            default:                            state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FS_IDLE;
        else     state <= state_nx;
    end

    assign cmd_valid = (state == FS_CMD);
    assign cmd_addr  = rd_addr;
    assign rsp_ready = (state == FS_WAIT) && hold_free;
    assign load      = rsp_valid && rsp_ready;

endmodule

// File: rtl/mfr_hold.sv
module mfr_hold #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          src_valid,
    input  logic          src_ready,
    output logic [DW-1:0] src_data,
    output logic          consume,
    output logic          free
);
    logic          full;
    logic [DW-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
        end else if (consume) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) word <= load_data;
    end

    assign consume   = full && src_ready;
    assign free      = !full;
    assign src_valid = full;
    assign src_data  = word;

endmodule

// File: rtl/mfr_stream_reader.sv
module mfr_stream_reader
    import mfr_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned RD_THRESH = 4,
    parameter int unsigned BASE      = 8,
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 32,
    localparam int unsigned LW       = level_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_log,
    output logic [LW-1:0] level,
    output logic          readable,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [AW-1:0] cmd_addr,
    input  logic          rsp_valid,
    output logic          rsp_ready,
    input  logic [DW-1:0] rsp_data,
    output logic          src_valid,
    input  logic          src_ready,
    output logic [DW-1:0] src_data
);
    logic [AW-1:0] rd_addr;
    logic          rd_stb;
    logic          hold_free;
    logic          load;

    mfr_level_ctrl #(
        .DEPTH(DEPTH), .RD_THRESH(RD_THRESH), .BASE(BASE), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_log(wr_log), .rd_stb(rd_stb),
        .level(level), .readable(readable), .rd_addr(rd_addr)
    );

    mfr_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst(rst), .readable(readable), .hold_free(hold_free),
        .rd_addr(rd_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .load(load)
    );

    mfr_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst(rst), .load(load), .load_data(rsp_data),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .consume(rd_stb), .free(hold_free)
    );

endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned RD_THRESH = 4,
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 32,
    localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_log,
    input logic [LW-1:0] level,
    input logic          readable,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [AW-1:0] cmd_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic          src_valid,
    input logic          src_ready,
    input logic [DW-1:0] src_data
);
    logic [1:0] outst;
    logic       cmd_hs, rsp_hs, src_hs;

    assign cmd_hs = cmd_valid && cmd_ready;
    assign rsp_hs = rsp_valid && rsp_ready;
    assign src_hs = src_valid && src_ready;

    always_ff @(posedge clk) begin
        if (rst) outst <= '0;
        else     outst <= outst + {1'b0, cmd_hs} - {1'b0, rsp_hs};
    end

    AST_NO_CMD_BELOW_MARK: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (int'(level) > RD_THRESH)); // R2
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !src_ready) |=> (src_valid && $stable(src_data))); // R4
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr))); // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (outst == 2'd0 && !src_valid)); // R5
    AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (rst)
        (src_hs && !wr_log) |=> (level == $past(level) - 1'b1)); // R6
    AST_LEVEL_SAME: assert property (@(posedge clk) disable iff (rst)
        (src_hs && wr_log) |=> (level == $past(level))); // R6
    AST_RSP_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> (outst == 2'd1 && !src_valid)); // R7
    AST_RSP_TO_SRC: assert property (@(posedge clk) disable iff (rst)
        rsp_hs |=> src_valid); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!src_valid && !cmd_valid && !rsp_ready && level == '0)); // R8

endmodule

bind mfr_stream_reader mfr_checker #(
    .DEPTH(DEPTH), .RD_THRESH(RD_THRESH), .AW(AW), .DW(DW)
) u_chk (
    .clk(clk), .rst(rst), .wr_log(wr_log), .level(level), .readable(readable),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data)
);

// File: tb/sim_mfr_stream_reader.sv
module sim_mfr_stream_reader;
    localparam int DEPTH = 8;
    localparam int THR   = 3;
    localparam int BASE  = 5;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int NW    = 3 * DEPTH + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_log = 1'b0;
    logic [LW-1:0] level;
    logic          readable;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [AW-1:0] cmd_addr;
    logic          rsp_valid = 1'b0;
    logic          rsp_ready;
    logic [DW-1:0] rsp_data = '0;
    logic          src_valid;
    logic          src_ready = 1'b0;
    logic [DW-1:0] src_data;

    int checks = 0;
    int errors = 0;
    int ncmd   = 0;

    always #10 clk = ~clk;

    mfr_stream_reader #(
        .DEPTH(DEPTH), .RD_THRESH(THR), .BASE(BASE), .AW(AW), .DW(DW)
    ) u0 (
        .clk(clk), .rst(rst), .wr_log(wr_log), .level(level), .readable(readable),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data)
    );

    function automatic logic [DW-1:0] mdata(int a);
        return DW'(a * 13 + 16'h0A51);
    endfunction

    function automatic int waddr(int n);
        return BASE + (n % DEPTH);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory responder: stalls the command and the return by index-dependent amounts
    initial begin : responder
        logic [AW-1:0] a;
        forever begin
            @(negedge clk);
            if (cmd_valid && !rst) begin
                repeat (ncmd % 2) @(negedge clk);
                a = cmd_addr;
                check(int'(a) == waddr(ncmd), "R1 cmd address", int'(a), waddr(ncmd));
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                ncmd++;
                repeat (ncmd % 3) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = mdata(int'(a));
                while (!rsp_ready) @(negedge clk);
                @(negedge clk);
                rsp_valid = 1'b0;
                check(src_valid == 1'b1, "R7 word presented after return", int'(src_valid), 1);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic log_write(input int exp_level);
        wr_log = 1'b1;
        @(negedge clk);
        wr_log = 1'b0;
        check(int'(level) == exp_level, "R6 level after write", int'(level), exp_level);
        check(readable == (exp_level > THR), "R3 readable flag", int'(readable), int'(exp_level > THR));
    endtask

    task automatic wait_src();
        while (!src_valid) @(negedge clk);
    endtask

    initial begin : main
        int n;
        int lvl;
        int cmds_before;
        logic [DW-1:0] held;

        repeat (3) @(negedge clk);
        check(src_valid == 0 && cmd_valid == 0 && rsp_ready == 0, "R8 reset outputs idle",
              int'({src_valid, cmd_valid, rsp_ready}), 0);
        check(level == 0 && readable == 0, "R8 reset level", int'(level), 0);
        rst = 1'b0;
        @(negedge clk);
        check(level == 0 && src_valid == 0, "R8 first cycle after reset", int'(level), 0);

        // fill up to the watermark: nothing may be fetched
        for (int i = 0; i < THR; i++) begin
            log_write(i + 1);
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(ncmd == 0, "R2 no command at watermark", ncmd, 0);
        check(src_valid == 0, "R2 no data at watermark", int'(src_valid), 0);

        // one more word crosses the watermark
        log_write(THR + 1);

        // steady stream: write log and consume share the same edge
        n = 0;
        for (int k = 0; k < NW; k++) begin
            wait_src();
            check(src_data == mdata(waddr(n)), "R1 word order", int'(src_data), int'(mdata(waddr(n))));
            held = src_data;
            for (int s = 0; s < k % 3; s++) begin
                @(negedge clk);
                check(src_valid && src_data == held, "R4 held word", int'(src_data), int'(held));
                check(!cmd_valid && !rsp_ready, "R5 no fetch while held",
                      int'({cmd_valid, rsp_ready}), 0);
            end
            lvl = int'(level);
            src_ready = 1'b1;
            wr_log = (k != NW - 1);
            @(negedge clk);
            src_ready = 1'b0;
            if (k != NW - 1) begin
                check(int'(level) == lvl, "R6 write and consume together", int'(level), lvl);
                check(readable == 1'b1, "R3 readable stays up", int'(readable), 1);
            end else begin
                check(int'(level) == lvl - 1, "R6 consume alone", int'(level), lvl - 1);
                check(readable == 1'b0, "R3 readable drops", int'(readable), 0);
            end
            wr_log = 1'b0;
            n++;
        end

        // below the watermark again: fetching stops
        cmds_before = ncmd;
        repeat (15) @(negedge clk);
        check(ncmd == cmds_before, "R2 fetch stops at watermark", ncmd, cmds_before);
        check(src_valid == 0, "R2 source idle at watermark", int'(src_valid), 0);

        // fill the window completely, then drain down to the watermark
        for (int i = THR; i < DEPTH; i++) begin
            log_write(i + 1);
        end
        for (int k = 0; k < DEPTH - THR; k++) begin
            wait_src();
            check(src_data == mdata(waddr(n)), "R1 drain order", int'(src_data), int'(mdata(waddr(n))));
            lvl = int'(level);
            src_ready = 1'b1;
            @(negedge clk);
            src_ready = 1'b0;
            check(int'(level) == lvl - 1, "R6 drain decrement", int'(level), lvl - 1);
            n++;
        end
        check(int'(level) == THR && readable == 0, "R3 drained to watermark", int'(level), THR);
        cmds_before = ncmd;
        repeat (15) @(negedge clk);
        check(ncmd == cmds_before && src_valid == 0, "R2 idle after drain", ncmd, cmds_before);

        summary();
    end

endmodule